// File: doc/BRIEF.md
# Port-Mapped Byte RAM Bridge

This block gives a controller that has only I/O-port operations access to a 256-byte RAM. The controller puts a small device code on three select lines and pulses a strobe. The block decodes that code into eight separate port strobes, and each strobe is also brought out for other devices. Four of the decoded ports serve the RAM. Every other code is left to external logic and does not affect the RAM side.

Addresses and data share the controller's single 8-bit bus, so each memory access takes two port operations. To read, the controller first sends an address to the read-address port and then inputs from the read-data port. To write, the controller first loads a data latch through the write-data port and then sends the address to the write-address port. That second operation commits the latched byte and also moves the address register to that address. A read immediately after a write therefore returns the stored byte. The storage is built as two 4-bit-wide arrays that together make up each byte.

Top module: `ioport_ram_bridge`

## Requirements
- R1: After reset the address register and the write latch hold 0x00. `rd_en` is low, `rd_data` is 0x00, and all port strobes are low while `io_strobe` is low.
- R2: While `io_strobe` is high, `port_strb` has exactly bit `io_sel` set. While `io_strobe` is low, `port_strb` is all zero.
- R3: A strobe on the read-address port (code 1) loads `wr_data` into the address register at the clock edge. It leaves the RAM contents unchanged.
- R4: During a strobe on the read-data port (code 2), `rd_en` is high and `rd_data` carries the byte at the address register in that same cycle. At all other times `rd_en` is low and `rd_data` is 0x00.
- R5: A strobe on the write-data port (code 3) loads `wr_data` into the write latch. It leaves the RAM contents and the address register unchanged.
- R6: A strobe on the write-address port (code 4) stores the write latch at address `wr_data` and loads that address into the address register, both at the same edge. A read-data strobe that follows at once returns the stored byte.
- R7: The write latch keeps its value across commits, so repeated write-address strobes store the same byte at each address given.
- R8: Strobes with codes 0, 5, 6 and 7 change neither the address register, the write latch nor the RAM.
- R9: The upper and lower nibbles of each byte are kept in separate 4-bit arrays, and both halves are written and read together. Patterns whose nibbles differ, such as 0xA5 and 0x5A, return intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_strobe | input | 1 | Controller I/O operation in progress |
| io_sel | input | 3 | Device-select code |
| wr_data | input | 8 | Controller bus, driven by the controller on output operations |
| rd_data | output | 8 | Byte returned to the controller bus, zero when not driving |
| rd_en | output | 1 | High while the block drives the bus |
| port_strb | output | 8 | Decoded one-per-port strobes |

## Verification
A write-address strobe does two things in one edge: it commits the latched byte to the RAM and it moves the address register. Both effects are judged by a read-data strobe issued in the very next cycle with no read-address operation in between. If that read returns the latched byte, the store went to the new address and the register followed it. A second pair of effects is also checked. A read-address strobe and a write-data strobe each load a register and must not touch memory. To provoke this, the bench preloads a known byte, issues those strobes in the middle of the sequence with conflicting data, and then confirms that the old byte still reads back.

// File: rtl/ioport_ram_bridge.sv
module ioport_ram_bridge #(
  parameter int ADDR_W  = 8,
  parameter int HALF_W  = 4,
  parameter int SEL_W   = 3,
  parameter int P_RADDR = 1,
  parameter int P_RDATA = 2,
  parameter int P_WDATA = 3,
  parameter int P_WADDR = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      io_strobe,
  input  logic [SEL_W-1:0]          io_sel,
  input  logic [2*HALF_W-1:0]       wr_data,
  output logic [2*HALF_W-1:0]       rd_data,
  output logic                      rd_en,
  output logic [(1<<SEL_W)-1:0]     port_strb
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = 2 * HALF_W;
  localparam int NPORT  = 1 << SEL_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wlatch_q;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    port_strb = '0;
    if (io_strobe) port_strb[io_sel] = 1'b1;
  end

  wire s_raddr = port_strb[P_RADDR];
  wire s_rdata = port_strb[P_RDATA];
  wire s_wdata = port_strb[P_WDATA];
  wire s_waddr = port_strb[P_WADDR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wlatch_q <= '0;
    end else begin
      if (s_raddr || s_waddr) addr_q <= wr_data[ADDR_W-1:0];
      if (s_wdata)            wlatch_q <= wr_data;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (rst_n && s_waddr)
        mem[wr_data[ADDR_W-1:0]] <= wlatch_q[h*HALF_W +: HALF_W];
    end
    assign rd_word[h*HALF_W +: HALF_W] = mem[addr_q];
  end

  assign rd_en   = s_rdata;
  assign rd_data = rd_en ? rd_word : '0;

  assert_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    io_strobe |-> ($countones(port_strb) == 1 && port_strb[io_sel]));
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_strobe |-> (port_strb == '0));
  assert_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
  assert_raddr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_sel == SEL_W'(P_RADDR)) |=> (addr_q == $past(wr_data[ADDR_W-1:0])));
  assert_raddr_nomem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_sel == SEL_W'(P_RADDR) && wr_data[ADDR_W-1:0] == addr_q)
      |=> $stable(rd_word));
  assert_wdata_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_sel == SEL_W'(P_WDATA)) |=> (wlatch_q == $past(wr_data) && $stable(addr_q)));
  assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_sel == SEL_W'(P_WADDR)) |=> (rd_word == $past(wlatch_q)));
  assert_other_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_sel != SEL_W'(P_RADDR) && io_sel != SEL_W'(P_WADDR)
     && io_sel != SEL_W'(P_WDATA)) |=> ($stable(addr_q) && $stable(wlatch_q)));
  assert_ports_R1: assert property (@(posedge clk)
    !rst_n |=> (addr_q == '0 && wlatch_q == '0));
  initial assert (NPORT > P_WADDR && NPORT > P_RDATA);
endmodule

// File: tb/test_ioport_ram_bridge.sv
module test_ioport_ram_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_strobe = 1'b0;
  logic [2:0] io_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rd_en;
  logic [7:0] port_strb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [2:0] C_RADDR = 3'd1, C_RDATA = 3'd2, C_WDATA = 3'd3, C_WADDR = 3'd4;

  ioport_ram_bridge i_ioport_ram_bridge (
    .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_sel(io_sel),
    .wr_data(wr_data), .rd_data(rd_data), .rd_en(rd_en), .port_strb(port_strb)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] sel, input logic [7:0] d,
                    output logic [7:0] rdat, output logic ren, output logic [7:0] strb);
    @(negedge clk);
    io_strobe = 1'b1; io_sel = sel; wr_data = d;
    #5;
    rdat = rd_data; ren = rd_en; strb = port_strb;
    @(posedge clk);
    #1;
    io_strobe = 1'b0; wr_data = 8'h00;
  endtask

  task automatic put(input logic [2:0] sel, input logic [7:0] d);
    logic [7:0] r; logic e; logic [7:0] s;
    op(sel, d, r, e, s);
  endtask

  task automatic get(input string req, input logic [7:0] exp);
    logic [7:0] r; logic e; logic [7:0] s;
    op(C_RDATA, 8'h00, r, e, s);
    check(req, {24'd0, r}, {24'd0, exp});
    check(req, {31'd0, e}, 32'd1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    put(C_WDATA, d);
    put(C_WADDR, a);
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    put(C_RADDR, a);
    get(req, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 strobes", {24'd0, port_strb}, 32'd0);
    check("R1 rd_en", {31'd0, rd_en}, 32'd0);
    check("R1 rd_data", {24'd0, rd_data}, 32'd0);
    put(C_WADDR, 8'h10);
    get("R1 latch zero", 8'h00);
    put(C_RADDR, 8'h11);
    put(C_WADDR, 8'h12);
    get("R1 latch zero again", 8'h00);
  endtask

  task automatic t_decode;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] r; logic e; logic [7:0] s;
      op(3'(k), 8'h00, r, e, s);
      check("R2 decode", {24'd0, s}, 32'(1 << k));
      check("R4 drive only on read port", {31'd0, e}, (k == 2) ? 32'd1 : 32'd0);
      if (k != 2) check("R4 bus zero", {24'd0, r}, 32'd0);
    end
    @(negedge clk);
    check("R2 idle", {24'd0, port_strb}, 32'd0);
  endtask

  task automatic t_write_read;
    wr(8'h00, 8'hA5); get("R6 immediate read", 8'hA5);
    wr(8'hFF, 8'h5A); get("R6 immediate read", 8'h5A);
    wr(8'h3C, 8'hFF); get("R6 immediate read", 8'hFF);
    wr(8'h81, 8'h0F); get("R6 immediate read", 8'h0F);
    rd("R9 nibbles A5", 8'h00, 8'hA5);
    rd("R9 nibbles 5A", 8'hFF, 8'h5A);
    rd("R9 ones", 8'h3C, 8'hFF);
    rd("R9 low nibble", 8'h81, 8'h0F);
    rd("R4 read repeat", 8'h00, 8'hA5);
    get("R4 second read same addr", 8'hA5);
  endtask

  task automatic t_raddr_nomem;
    wr(8'h20, 8'h77);
    put(C_WDATA, 8'h11);
    put(C_RADDR, 8'h20);
    get("R3 raddr leaves ram", 8'h77);
    put(C_RADDR, 8'h21);
    put(C_RADDR, 8'h20);
    get("R3 addr reload", 8'h77);
  endtask

  task automatic t_wdata_nomem;
    wr(8'h30, 8'h44);
    put(C_RADDR, 8'h30);
    put(C_WDATA, 8'h99);
    get("R5 wdata leaves ram and addr", 8'h44);
    put(C_WADDR, 8'h31);
    put(C_WADDR, 8'h32);
    get("R7 latch kept", 8'h99);
    rd("R7 first copy", 8'h31, 8'h99);
    rd("R5 ram intact", 8'h30, 8'h44);
  endtask

  task automatic t_other_ports;
    wr(8'h40, 8'hC3);
    put(C_RADDR, 8'h40);
    put(C_WDATA, 8'h5E);
    put(3'd0, 8'h41); put(3'd5, 8'h42); put(3'd6, 8'h43); put(3'd7, 8'h44);
    get("R8 addr held", 8'hC3);
    put(C_WADDR, 8'h45);
    get("R8 latch held", 8'h5E);
    rd("R8 ram held", 8'h41, 8'hE7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_decode();
    t_write_read();
    t_raddr_nomem();
    t_wdata_nomem();
    wr(8'h41, 8'hE7);
    t_other_ports();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule